// File: doc/BRIEF.md
# Cache Access Policy Controller

This block sits between a cache's tag lookup and its lower-memory request queue. It receives the outcome of a tag probe (hit, miss or reservation fail), together with the kind of access: read or write, atomic, and local or global. It then applies a statically configured set of policies and decides three things: the status returned to the requester, which requests are pushed toward lower memory, and which update is applied to the probed line. The pushed requests can be a forwarded write, a line fill, or a write-back of a dirty victim. Tag storage, the data array and the miss-tracking table are outside the block. The block only sees a merge-hit flag and a free-entry flag from the miss tracker, plus the current occupancy of the miss queue.

Admission is decided for the worst case. Each access path needs a known maximum number of queue slots: one for a forwarded write, two for a read miss, three for an allocating write miss. The access is accepted only if that many slots are free and, for misses that allocate, the miss tracker can take the request. A rejected access returns reservation fail and has no side effect. The policy configuration is captured while reset is held. An encoding outside the legal set raises an error flag, and while that flag is set every access is refused.

Top module: `cache_policy_ctrl`

## Requirements
- R1: A probe code of 2 or 3 (reservation fail) is returned as status 2 (reservation fail), with no request pushed and no line update.
- R2: The write-hit policy code (0 write-back, 1 write-through, 2 write-evict, 3 local write-back / global write-evict) and the write-allocate flag are captured while rst_n is low, and later changes are ignored. Codes 4 to 7 set cfg_err_o, and every access is then answered with status 2 and no action.
- R3: Under write-back, a write hit returns status 0 (hit), touches the LRU state and marks the line dirty, with no push.
- R4: Under write-through, a write hit needs one free queue slot. It then returns hit, touches the LRU state and pushes a write; without the slot it returns status 2.
- R5: Under write-evict, a write hit needs one free slot. It then returns hit, invalidates the line and pushes a write. Under policy 3, a local write hit follows R3 and a global one follows this rule.
- R6: A write miss without write-allocate needs one free slot. It then pushes the write and returns status 1 (miss); otherwise it returns status 2.
- R7: A write miss with write-allocate needs three free slots and a free miss-tracker entry, otherwise it returns status 2. When accepted it pushes the write and returns miss. It also pushes a fill only when the block is not already tracked. It pushes a write-back only when the block is not tracked, the victim is dirty and the policy is not write-through.
- R8: A read hit returns hit and touches the LRU state. If the access is atomic, the line is also marked dirty. Nothing is pushed.
- R9: A read miss needs two free slots and a free miss-tracker entry, otherwise it returns status 2. When accepted it returns miss, with the fill and write-back conditions of R7.
- R10: Results appear one clock after the access is presented. A cycle without an access, and the reset state, give rsp_valid_o low with no push and no line update.
- R11: The number of requests pushed for one access never exceeds the free slots of the miss queue when the access was presented.

Free slots are MQ_DEPTH minus mq_used_i, counted as zero when the occupancy reaches the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_wr_hit_i | input | 3 | Write-hit policy code |
| cfg_wr_alloc_i | input | 1 | Write-allocate on write miss |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_write_i | input | 1 | Access is a write |
| acc_atomic_i | input | 1 | Access is atomic |
| acc_local_i | input | 1 | Access targets local (per-thread) space |
| probe_i | input | 2 | Tag probe result: 0 hit, 1 miss, 2/3 reservation fail |
| victim_dirty_i | input | 1 | Line chosen for eviction is dirty |
| mshr_hit_i | input | 1 | Block already tracked by the miss tracker |
| mshr_avail_i | input | 1 | Miss tracker can accept this block |
| mq_used_i | input | $clog2(MQ_DEPTH+1) | Current miss-queue occupancy |
| rsp_valid_o | output | 1 | Response valid |
| rsp_status_o | output | 2 | 0 hit, 1 miss, 2 reservation fail |
| push_write_o | output | 1 | Push a forwarded write |
| push_fill_o | output | 1 | Push a line fill read |
| push_wb_o | output | 1 | Push a victim write-back |
| line_touch_o | output | 1 | Update LRU state of the probed line |
| line_dirty_o | output | 1 | Mark the probed line modified |
| line_inval_o | output | 1 | Invalidate the probed line |
| cfg_err_o | output | 1 | Captured write-hit code is illegal |

## Verification
Every result of an access is due exactly one rising edge after the access is driven: the status, the pushes and the line update all come from a single register stage. The captured configuration and its error flag are settled at the first edge with reset low. The bench drives each access on a falling edge and compares all outputs at the following falling edge, so the value it reads is always the one registered from that access. The free-slot corner cases for one, two and three slots are driven at their exact boundaries, one slot above and at the limit.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    // probe codes (bit 1 set means the tag array refused the access)
    localparam logic [1:0] PRB_HIT  = 2'd0;
    localparam logic [1:0] PRB_MISS = 2'd1;

    // response status codes
    localparam logic [1:0] ST_HIT  = 2'd0;
    localparam logic [1:0] ST_MISS = 2'd1;
    localparam logic [1:0] ST_RSV  = 2'd2;

    // write-hit policy codes
    localparam logic [2:0] WH_BACK  = 3'd0;
    localparam logic [2:0] WH_THRU  = 3'd1;
    localparam logic [2:0] WH_EVICT = 3'd2;
    localparam logic [2:0] WH_SPLIT = 3'd3;

    // largest number of queue pushes one access can make
    localparam int MAX_REQ = 3;

    typedef struct packed {
        logic [2:0] hit_pol;
        logic       alloc;
        logic       err;
    } cfg_t;

    typedef struct packed {
        logic       valid;
        logic [1:0] status;
        logic       push_wr;
        logic       push_fill;
        logic       push_wb;
        logic       touch;
        logic       dirty;
        logic       inval;
    } result_t;

endpackage

// File: rtl/cpc_cfg.sv
module cpc_cfg
    import cpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hit_code_i,
    input  logic       alloc_i,
    output cfg_t       cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.hit_pol = hit_code_i;
            cfg_d.alloc   = alloc_i;
            cfg_d.err     = (hit_code_i > WH_SPLIT);
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/cpc_room.sv
module cpc_room
    import cpc_pkg::*;
#(
    parameter int MQ_DEPTH = 8,
    localparam int CW = $clog2(MQ_DEPTH + 1)
) (
    input  logic [CW-1:0]      used_i,
    output logic [MAX_REQ:1]   room_o
);
    // room_o[k] is set when k more requests fit in the queue
    for (genvar k = 1; k <= MAX_REQ; k++) begin : g_room
        assign room_o[k] = (32'(used_i) + 32'(k)) <= 32'(MQ_DEPTH);
    end
endmodule

// File: rtl/cpc_decide.sv
module cpc_decide
    import cpc_pkg::*;
(
    input  logic             valid_i,
    input  logic             write_i,
    input  logic             atomic_i,
    input  logic             local_i,
    input  logic [1:0]       probe_i,
    input  logic             victim_dirty_i,
    input  logic             mshr_hit_i,
    input  logic             mshr_avail_i,
    input  logic [MAX_REQ:1] room_i,
    input  cfg_t             cfg_i,
    output result_t          res_o
);
    logic [2:0] eff_pol;
    logic       wb_ok;

    always_comb begin
        eff_pol = cfg_i.hit_pol;
        if (cfg_i.hit_pol == WH_SPLIT) begin
            eff_pol = local_i ? WH_BACK : WH_EVICT;
        end
        wb_ok = victim_dirty_i && !mshr_hit_i && (cfg_i.hit_pol != WH_THRU);

        res_o = '0;
        if (valid_i) begin
            res_o.valid  = 1'b1;
            res_o.status = ST_RSV;
            if (!cfg_i.err && !probe_i[1]) begin
                if (write_i && probe_i == PRB_HIT) begin
                    unique case (eff_pol)
                        WH_BACK: begin
                            res_o.status = ST_HIT;
                            res_o.touch  = 1'b1;
                            res_o.dirty  = 1'b1;
                        end
                        WH_THRU: if (room_i[1]) begin
                            res_o.status  = ST_HIT;
                            res_o.touch   = 1'b1;
                            res_o.push_wr = 1'b1;
                        end
                        default: if (room_i[1]) begin
                            res_o.status  = ST_HIT;
                            res_o.inval   = 1'b1;
                            res_o.push_wr = 1'b1;
                        end
                    endcase
                end else if (write_i) begin
                    if (!cfg_i.alloc) begin
                        if (room_i[1]) begin
                            res_o.status  = ST_MISS;
                            res_o.push_wr = 1'b1;
                        end
                    end else if (room_i[3] && mshr_avail_i) begin
                        res_o.status    = ST_MISS;
                        res_o.push_wr   = 1'b1;
                        res_o.push_fill = !mshr_hit_i;
                        res_o.push_wb   = wb_ok;
                    end
                end else if (probe_i == PRB_HIT) begin
                    res_o.status = ST_HIT;
                    res_o.touch  = 1'b1;
                    res_o.dirty  = atomic_i;
                end else if (room_i[2] && mshr_avail_i) begin
                    res_o.status    = ST_MISS;
                    res_o.push_fill = !mshr_hit_i;
                    res_o.push_wb   = wb_ok;
                end
            end
        end
    end
endmodule

// File: rtl/cache_policy_ctrl.sv
module cache_policy_ctrl
    import cpc_pkg::*;
#(
    parameter int MQ_DEPTH = 8,
    localparam int CW = $clog2(MQ_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cfg_wr_hit_i,
    input  logic          cfg_wr_alloc_i,
    input  logic          acc_valid_i,
    input  logic          acc_write_i,
    input  logic          acc_atomic_i,
    input  logic          acc_local_i,
    input  logic [1:0]    probe_i,
    input  logic          victim_dirty_i,
    input  logic          mshr_hit_i,
    input  logic          mshr_avail_i,
    input  logic [CW-1:0] mq_used_i,
    output logic          rsp_valid_o,
    output logic [1:0]    rsp_status_o,
    output logic          push_write_o,
    output logic          push_fill_o,
    output logic          push_wb_o,
    output logic          line_touch_o,
    output logic          line_dirty_o,
    output logic          line_inval_o,
    output logic          cfg_err_o
);
    cfg_t              cfg;
    logic [MAX_REQ:1]  room;
    result_t           dec_res;
    result_t           rsp_d, rsp_q;

    cpc_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_code_i (cfg_wr_hit_i),
        .alloc_i    (cfg_wr_alloc_i),
        .cfg_o      (cfg)
    );

    cpc_room #(.MQ_DEPTH(MQ_DEPTH)) u_room (
        .used_i (mq_used_i),
        .room_o (room)
    );

    cpc_decide u_decide (
        .valid_i        (acc_valid_i),
        .write_i        (acc_write_i),
        .atomic_i       (acc_atomic_i),
        .local_i        (acc_local_i),
        .probe_i        (probe_i),
        .victim_dirty_i (victim_dirty_i),
        .mshr_hit_i     (mshr_hit_i),
        .mshr_avail_i   (mshr_avail_i),
        .room_i         (room),
        .cfg_i          (cfg),
        .res_o          (dec_res)
    );

    always_comb begin
        rsp_d = dec_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid_o  = rsp_q.valid;
    assign rsp_status_o = rsp_q.status;
    assign push_write_o = rsp_q.push_wr;
    assign push_fill_o  = rsp_q.push_fill;
    assign push_wb_o    = rsp_q.push_wb;
    assign line_touch_o = rsp_q.touch;
    assign line_dirty_o = rsp_q.dirty;
    assign line_inval_o = rsp_q.inval;
    assign cfg_err_o    = cfg.err;
endmodule

// File: rtl/cpc_chk.sv
module cpc_chk #(
    parameter int MQ_DEPTH = 8,
    localparam int CW = $clog2(MQ_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid_i,
    input logic          acc_write_i,
    input logic [1:0]    probe_i,
    input logic [CW-1:0] mq_used_i,
    input logic          rsp_valid_o,
    input logic [1:0]    rsp_status_o,
    input logic          push_write_o,
    input logic          push_fill_o,
    input logic          push_wb_o,
    input logic          line_touch_o,
    input logic          line_dirty_o,
    input logic          line_inval_o,
    input logic          cfg_err_o
);
    a_r1_refused_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && probe_i[1]) |=> (rsp_status_o == 2'd2 && !push_write_o
            && !push_fill_o && !push_wb_o && !line_touch_o && !line_dirty_o && !line_inval_o));

    a_r2_err_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && cfg_err_o) |=> (rsp_status_o == 2'd2
            && $countones({push_write_o, push_fill_o, push_wb_o}) == 0));

    a_r2_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(cfg_err_o));

    a_r8_hit_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_status_o == 2'd0) |-> (!push_fill_o && !push_wb_o));

    a_r5_line_op_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({line_dirty_o, line_inval_o}));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid_i |=> (!rsp_valid_o && !push_write_o && !push_fill_o && !push_wb_o
            && !line_touch_o && !line_dirty_o && !line_inval_o));

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i |=> (32'($countones({push_write_o, push_fill_o, push_wb_o}))
            + 32'($past(mq_used_i))) <= 32'(MQ_DEPTH));

    a_r7_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && !acc_write_i) |=> !push_write_o);
endmodule

bind cache_policy_ctrl cpc_chk #(.MQ_DEPTH(MQ_DEPTH)) u_chk (.*);

// File: tb/cache_policy_ctrl_tb.sv
`timescale 1ns/1ps
module cache_policy_ctrl_tb;
    localparam int MQ_DEPTH = 8;
    localparam int CW = $clog2(MQ_DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_wr_hit_i = '0;
    logic          cfg_wr_alloc_i = 1'b0;
    logic          acc_valid_i = 1'b0;
    logic          acc_write_i = 1'b0;
    logic          acc_atomic_i = 1'b0;
    logic          acc_local_i = 1'b0;
    logic [1:0]    probe_i = '0;
    logic          victim_dirty_i = 1'b0;
    logic          mshr_hit_i = 1'b0;
    logic          mshr_avail_i = 1'b0;
    logic [CW-1:0] mq_used_i = '0;
    logic          rsp_valid_o;
    logic [1:0]    rsp_status_o;
    logic          push_write_o, push_fill_o, push_wb_o;
    logic          line_touch_o, line_dirty_o, line_inval_o;
    logic          cfg_err_o;

    int total = 0;
    int bad = 0;
    int cur_pol = 0;
    bit cur_alloc = 1'b0;

    always #4 clk = ~clk;

    cache_policy_ctrl #(.MQ_DEPTH(MQ_DEPTH)) u_dut (.*);

    // {valid, status[1:0], write, fill, wb, touch, dirty, inval}
    function automatic logic [8:0] model(input bit v, w, at, lc, input logic [1:0] p,
                                         input bit vd, mh, ma, input int used);
        int  free;
        int  pol;
        bit  wbk;
        logic [1:0] st;
        bit pw, pf, pb, tc, dt, iv;
        free = (used >= MQ_DEPTH) ? 0 : MQ_DEPTH - used;
        if (!v) return 9'd0;
        st = 2'd2; pw = 0; pf = 0; pb = 0; tc = 0; dt = 0; iv = 0;
        pol = (cur_pol == 3) ? (lc ? 0 : 2) : cur_pol;
        wbk = vd && !mh && (cur_pol != 1);
        if (cur_pol <= 3 && p[1] == 1'b0) begin
            if (w && p == 2'd0) begin
                if (pol == 0) begin st = 0; tc = 1; dt = 1; end
                else if (free >= 1) begin
                    st = 0; pw = 1;
                    if (pol == 1) tc = 1; else iv = 1;
                end
            end else if (w) begin
                if (!cur_alloc) begin
                    if (free >= 1) begin st = 1; pw = 1; end
                end else if (free >= 3 && ma) begin
                    st = 1; pw = 1; pf = !mh; pb = wbk;
                end
            end else if (p == 2'd0) begin
                st = 0; tc = 1; dt = at;
            end else if (free >= 2 && ma) begin
                st = 1; pf = !mh; pb = wbk;
            end
        end
        return {1'b1, st, pw, pf, pb, tc, dt, iv};
    endfunction

    function automatic string tag_of(input bit v, w, lc, input logic [1:0] p);
        if (!v) return "R10";
        if (p[1]) return "R1";
        if (cur_pol > 3) return "R2";
        if (w && p == 2'd0) begin
            if (cur_pol == 0 || (cur_pol == 3 && lc)) return "R3";
            if (cur_pol == 1) return "R4";
            return "R5";
        end
        if (w) return cur_alloc ? "R7" : "R6";
        if (p == 2'd0) return "R8";
        return "R9";
    endfunction

    function automatic logic [8:0] observed();
        return {rsp_valid_o, rsp_status_o, push_write_o, push_fill_o, push_wb_o,
                line_touch_o, line_dirty_o, line_inval_o};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic access(input bit v, w, at, lc, input logic [1:0] p,
                          input bit vd, mh, ma, input int used);
        logic [8:0] exp;
        acc_valid_i = v; acc_write_i = w; acc_atomic_i = at; acc_local_i = lc;
        probe_i = p; victim_dirty_i = vd; mshr_hit_i = mh; mshr_avail_i = ma;
        mq_used_i = CW'(used);
        exp = model(v, w, at, lc, p, vd, mh, ma, used);
        @(posedge clk);
        @(negedge clk);
        check(tag_of(v, w, lc, p), observed(), exp);
    endtask

    task automatic start_phase(input int pol, input bit alloc);
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid_i = 1'b0;
        cfg_wr_hit_i = 3'(pol);
        cfg_wr_alloc_i = alloc;
        repeat (3) @(negedge clk);
        check("R10", observed(), 9'd0);
        total++;
        if (cfg_err_o !== (pol > 3)) begin
            bad++;
            $display("FAIL R2 actual=%b expected=%b", cfg_err_o, (pol > 3));
        end
        cur_pol = pol;
        cur_alloc = alloc;
        rst_n = 1'b1;
        // R2: configuration changes after reset must be ignored
        cfg_wr_hit_i = 3'($urandom_range(0, 7));
        cfg_wr_alloc_i = 1'($urandom_range(0, 1));
    endtask

    task automatic directed();
        // R9 boundary: two slots needed for a read miss
        access(1, 0, 0, 0, 2'd1, 1, 0, 1, MQ_DEPTH - 2);
        access(1, 0, 0, 0, 2'd1, 1, 0, 1, MQ_DEPTH - 1);
        access(1, 0, 0, 0, 2'd1, 1, 1, 1, MQ_DEPTH - 2);
        access(1, 0, 0, 0, 2'd1, 0, 0, 0, 0);
        // R7/R6 boundary: three slots for allocate, one otherwise
        access(1, 1, 0, 0, 2'd1, 1, 0, 1, MQ_DEPTH - 3);
        access(1, 1, 0, 0, 2'd1, 1, 0, 1, MQ_DEPTH - 2);
        access(1, 1, 0, 0, 2'd1, 0, 0, 1, MQ_DEPTH - 1);
        access(1, 1, 0, 0, 2'd1, 0, 0, 0, MQ_DEPTH);
        // R4/R5: write hit at the last free slot and with the queue full
        access(1, 1, 0, 0, 2'd0, 0, 0, 1, MQ_DEPTH - 1);
        access(1, 1, 0, 0, 2'd0, 0, 0, 1, MQ_DEPTH);
        access(1, 1, 0, 1, 2'd0, 0, 0, 1, MQ_DEPTH);
        // R8 atomic read hit, R1 refused probes, R10 idle
        access(1, 0, 1, 0, 2'd0, 0, 0, 1, 0);
        access(1, 0, 0, 0, 2'd2, 1, 0, 1, 0);
        access(1, 1, 0, 0, 2'd3, 1, 0, 1, 0);
        access(0, 1, 0, 0, 2'd1, 1, 0, 1, 0);
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            access($urandom_range(0, 9) != 0, 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   ($urandom_range(0, 9) < 8) ? 2'($urandom_range(0, 1)) : 2'($urandom_range(2, 3)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   $urandom_range(0, 3) != 0, $urandom_range(0, MQ_DEPTH));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int pol = 0; pol < 4; pol++) begin
            for (int al = 0; al < 2; al++) begin
                start_phase(pol, 1'(al));
                directed();
                random_run(300);
            end
        end
        start_phase(4, 1'b1);
        directed();
        random_run(100);
        start_phase(7, 1'b0);
        random_run(100);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule